// File: doc/BRIEF.md
# Cache Line Autoload Prefetcher

This block sits beside an instruction cache and produces line-fill requests ahead of demand. Each cache lookup is reported as an access event carrying the address and whether it hit. When autoload is enabled and the event matches the selected trigger mode and falls inside one of two enabled address windows, the block computes the neighbouring line, one line up or one line down, and offers it as a fill request. It only does so if that line still lies inside the window that matched. Software can also start a manual preload that walks every line of one address range in a chosen order. Autoload is set aside while the preload runs and can be brought back afterwards.

Fill requests leave on a valid/ready stream. A request stays presented, with its address unchanged, until `req_ready` is high at a clock edge. There are two exceptions. In autoload mode a newer trigger overwrites a waiting request. While `freeze` is high the block rejects fills in the same way the cache rejects CPU misses: `req_valid` is held low, a waiting autoload request is dropped, new triggers are ignored, and preload lines are discarded at one per cycle. Control commands are single-cycle pulses. Status outputs are plain levels.

Top module: `line_prefetch_top`

## Requirements
- R1: Line size is chosen by `cfg_line_sel`: 0 = 16 bytes, 1 = 32 bytes, 2 or 3 = 64 bytes. Every request address is the start of a line of that size.
- R2: `cfg_trig` selects what triggers autoload: 0 = miss only (`acc_hit`=0), 1 = hit only, 2 = either, 3 = nothing.
- R3: A window i covers byte addresses base_i <= a < base_i + size_i and counts only when `cfg_reg_en[i]` is 1. Window i is packed at bits [i*AW +: AW] of `cfg_reg_base` and `cfg_reg_size`. When windows overlap, the lower index is the triggering window.
- R4: A trigger requests the line aligned from the access address plus one line (`cfg_dir`=0) or minus one line (`cfg_dir`=1). If that line does not lie inside the triggering window, or the step would wrap, no request is made. The request appears one cycle after the access.
- R5: An autoload trigger that arrives while a request is waiting replaces its address. This holds even in a cycle where the old request is accepted.
- R6: Once raised, `req_valid` stays high with a stable `req_addr` until a cycle with `req_ready` high, except as R5, R8 and R10 allow. It drops after the accepting edge when nothing follows.
- R7: `pl_start` walks the lines from align(`pl_addr`) to align(`pl_addr`+`pl_size`-1). The walk is ascending when `pl_order`=0 and descending when it is 1, with one request per line. A size of 0 issues nothing. `pl_done` is 0 from the cycle after the start until the edge that accepts the last line, and 1 at all other times.
- R8: `pl_start` copies `auto_active` into `saved_auto` and clears `auto_active`. `pl_end` stops any walk in progress and reloads `auto_active` from `saved_auto`. Command priority is `pl_start` > `pl_end` > `suspend` > `resume` > `auto_on` > `auto_off`.
- R9: `suspend` copies `auto_active` into `saved_auto` and clears it. `resume` sets `auto_active` to 1 exactly when `resume_val` is nonzero.
- R10: While `freeze` is 1, `req_valid` is 0. A waiting autoload request is dropped and access events cause nothing. Each frozen cycle discards the current preload line and advances the walk.
- R11: `busy` is 1 while a preload walk is active or a request is waiting, and 0 otherwise.
- R12: After reset, `auto_active`=0, `saved_auto`=0, `req_valid`=0, `pl_done`=1 and `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_line_sel | input | 2 | Line size select |
| cfg_dir | input | 1 | Autoload step: 0 up, 1 down |
| cfg_trig | input | 2 | Trigger mode |
| cfg_reg_en | input | NREG | Window enables |
| cfg_reg_base | input | NREG*AW | Window start addresses, packed |
| cfg_reg_size | input | NREG*AW | Window sizes in bytes, packed |
| auto_on | input | 1 | Pulse: enable autoload |
| auto_off | input | 1 | Pulse: disable autoload |
| suspend | input | 1 | Pulse: save and halt autoload |
| resume | input | 1 | Pulse: restore autoload from `resume_val` |
| resume_val | input | 8 | Nonzero re-enables autoload on resume |
| pl_start | input | 1 | Pulse: start manual preload |
| pl_addr | input | AW | Preload start address |
| pl_size | input | AW | Preload size in bytes |
| pl_order | input | 1 | Preload order: 0 ascending, 1 descending |
| pl_end | input | 1 | Pulse: end preload, restore autoload |
| acc_valid | input | 1 | Cache access event |
| acc_addr | input | AW | Access address |
| acc_hit | input | 1 | Access hit (1) or miss (0) |
| freeze | input | 1 | Cache frozen, fills rejected |
| req_valid | output | 1 | Fill request valid |
| req_ready | input | 1 | Fill request accepted |
| req_addr | output | AW | Fill line address |
| auto_active | output | 1 | Autoload currently enabled |
| saved_auto | output | 1 | Enable state saved by last suspend/preload start |
| pl_done | output | 1 | 0 while a preload walk is in progress |
| busy | output | 1 | Walk active or request waiting |

## Verification
Two functions can land in the same cycle. The first is autoload replacement meeting an accepting handshake. The bench holds a request and then drives a new in-window access together with `req_ready` high. It expects the new line, not an idle output, after the edge. The second is freeze meeting a preload walk. The bench raises `freeze` for two cycles right after the first line appears, then checks that exactly those two lines never show up and that the walk resumes at the third line.

// File: rtl/lpf_pkg.sv
`timescale 1ns/1ps
package lpf_pkg;
  typedef enum logic [1:0] {
    TRIG_MISS = 2'd0,
    TRIG_HIT  = 2'd1,
    TRIG_BOTH = 2'd2,
    TRIG_NONE = 2'd3
  } trig_mode_e;

  function automatic logic [2:0] line_shift(input logic [1:0] sel);
    case (sel)
      2'd0:    line_shift = 3'd4;
      2'd1:    line_shift = 3'd5;
      default: line_shift = 3'd6;
    endcase
  endfunction

  function automatic logic trig_match(input logic [1:0] mode, input logic hit);
    case (trig_mode_e'(mode))
      TRIG_MISS: trig_match = !hit;
      TRIG_HIT:  trig_match = hit;
      TRIG_BOTH: trig_match = 1'b1;
      default:   trig_match = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/lpf_step.sv
`timescale 1ns/1ps
module lpf_step #(
  parameter int AW = 24
) (
  input  logic [AW-1:0] addr,
  input  logic [2:0]    sh,
  input  logic          dir,
  output logic [AW-1:0] line,
  output logic [AW-1:0] next,
  output logic          next_ok
);
  logic [AW-1:0] lbytes;
  logic [AW:0]   up_sum;

  assign lbytes = AW'(1) << sh;
  assign line   = addr & ({AW{1'b1}} << sh);
  assign up_sum = {1'b0, line} + {1'b0, lbytes};

  always_comb begin
    if (dir) begin
      next    = line - lbytes;
      next_ok = (line >= lbytes);
    end else begin
      next    = up_sum[AW-1:0];
      next_ok = !up_sum[AW];
    end
  end
endmodule

// File: rtl/lpf_region_match.sv
`timescale 1ns/1ps
module lpf_region_match #(
  parameter int AW = 24
) (
  input  logic          en,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] size,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] cand,
  output logic          hit,
  output logic          cand_in
);
  logic [AW:0] lim;
  assign lim     = {1'b0, base} + {1'b0, size};
  assign hit     = en && ({1'b0, addr} >= {1'b0, base}) && ({1'b0, addr} < lim);
  assign cand_in = ({1'b0, cand} >= {1'b0, base}) && ({1'b0, cand} < lim);
endmodule

// File: rtl/lpf_ctrl.sv
`timescale 1ns/1ps
module lpf_ctrl #(
  parameter int RVW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pl_start,
  input  logic           pl_end,
  input  logic           suspend,
  input  logic           resume,
  input  logic [RVW-1:0] resume_val,
  input  logic           auto_on,
  input  logic           auto_off,
  output logic           auto_q,
  output logic           saved_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q  <= 1'b0;
      saved_q <= 1'b0;
    end else if (pl_start) begin
      saved_q <= auto_q;
      auto_q  <= 1'b0;
    end else if (pl_end) begin
      auto_q <= saved_q;
    end else if (suspend) begin
      saved_q <= auto_q;
      auto_q  <= 1'b0;
    end else if (resume) begin
      auto_q <= |resume_val;
    end else if (auto_on) begin
      auto_q <= 1'b1;
    end else if (auto_off) begin
      auto_q <= 1'b0;
    end
  end

  assert_pl_save_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pl_start |=> (!auto_q && saved_q == $past(auto_q)));
  assert_pl_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pl_start && pl_end) |=> (auto_q == $past(saved_q)));
  assert_suspend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pl_start && !pl_end && suspend) |=> (!auto_q && saved_q == $past(auto_q)));
  assert_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pl_start && !pl_end && !suspend && resume) |=> (auto_q == ($past(resume_val) != '0)));
endmodule

// File: rtl/lpf_fetch_gen.sv
`timescale 1ns/1ps
module lpf_fetch_gen #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    sh,
  input  logic          trig_fire,
  input  logic [AW-1:0] trig_addr,
  input  logic          pl_start,
  input  logic [AW-1:0] pl_addr,
  input  logic [AW-1:0] pl_size,
  input  logic          pl_order,
  input  logic          pl_end,
  input  logic          freeze,
  input  logic          req_ready,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  output logic          pend,
  output logic          pl_active
);
  logic [AW-1:0] addr_q, last_q, mask, pl_lo, pl_hi, pl_tail;
  logic          dir_q;
  logic [AW-1:0] step_line, step_next;
  logic          step_ok;
  logic          advance;

  assign mask    = {AW{1'b1}} << sh;
  assign pl_tail = pl_addr + pl_size - AW'(1);
  assign pl_lo   = pl_addr & mask;
  assign pl_hi   = pl_tail & mask;

  lpf_step #(.AW(AW)) i_walk_step (
    .addr(addr_q), .sh(sh), .dir(dir_q),
    .line(step_line), .next(step_next), .next_ok(step_ok)
  );

  assign advance = pend && (freeze || req_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pl_active <= 1'b0;
      addr_q    <= '0;
      last_q    <= '0;
      dir_q     <= 1'b0;
    end else if (pl_start) begin
      pend      <= (pl_size != '0);
      pl_active <= (pl_size != '0);
      dir_q     <= pl_order;
      addr_q    <= pl_order ? pl_hi : pl_lo;
      last_q    <= pl_order ? pl_lo : pl_hi;
    end else if (pl_active) begin
      if (pl_end) begin
        pend      <= 1'b0;
        pl_active <= 1'b0;
      end else if (advance) begin
        if (addr_q == last_q || !step_ok) begin
          pend      <= 1'b0;
          pl_active <= 1'b0;
        end else begin
          addr_q <= step_next;
        end
      end
    end else if (trig_fire) begin
      pend   <= 1'b1;
      addr_q <= trig_addr;
    end else if (freeze) begin
      pend <= 1'b0;
    end else if (pend && req_ready) begin
      pend <= 1'b0;
    end
  end

  assign req_valid = pend && !freeze;
  assign req_addr  = addr_q;

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_active && pend && !freeze && !req_ready && !pl_start && !pl_end)
      |=> (pend && $stable(addr_q)));
  assert_freeze_discard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_active && pend && freeze && !pl_start && !pl_end && addr_q != last_q)
      |=> (addr_q != $past(addr_q)));
endmodule

// File: rtl/line_prefetch_top.sv
`timescale 1ns/1ps
module line_prefetch_top #(
  parameter int AW   = 24,
  parameter int NREG = 2,
  parameter int RVW  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfg_line_sel,
  input  logic               cfg_dir,
  input  logic [1:0]         cfg_trig,
  input  logic [NREG-1:0]    cfg_reg_en,
  input  logic [NREG*AW-1:0] cfg_reg_base,
  input  logic [NREG*AW-1:0] cfg_reg_size,
  input  logic               auto_on,
  input  logic               auto_off,
  input  logic               suspend,
  input  logic               resume,
  input  logic [RVW-1:0]     resume_val,
  input  logic               pl_start,
  input  logic [AW-1:0]      pl_addr,
  input  logic [AW-1:0]      pl_size,
  input  logic               pl_order,
  input  logic               pl_end,
  input  logic               acc_valid,
  input  logic [AW-1:0]      acc_addr,
  input  logic               acc_hit,
  input  logic               freeze,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [AW-1:0]      req_addr,
  output logic               auto_active,
  output logic               saved_auto,
  output logic               pl_done,
  output logic               busy
);
  import lpf_pkg::*;

  logic [2:0]    sh;
  logic [AW-1:0] acc_line, cand;
  logic          cand_ok;
  logic [NREG-1:0] reg_hit, reg_cin;
  logic          win_hit, win_cin;
  logic          trig_fire;
  logic          pend, pl_active;

  assign sh = line_shift(cfg_line_sel);

  lpf_step #(.AW(AW)) i_acc_step (
    .addr(acc_addr), .sh(sh), .dir(cfg_dir),
    .line(acc_line), .next(cand), .next_ok(cand_ok)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_win
    lpf_region_match #(.AW(AW)) i_match (
      .en(cfg_reg_en[g]),
      .base(cfg_reg_base[g*AW +: AW]),
      .size(cfg_reg_size[g*AW +: AW]),
      .addr(acc_addr),
      .cand(cand),
      .hit(reg_hit[g]),
      .cand_in(reg_cin[g])
    );
  end

  always_comb begin
    win_hit = 1'b0;
    win_cin = 1'b0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (reg_hit[i]) begin
        win_hit = 1'b1;
        win_cin = reg_cin[i];
      end
    end
  end

  assign trig_fire = acc_valid && auto_active && !freeze && !pl_active &&
                     trig_match(cfg_trig, acc_hit) && win_hit && win_cin && cand_ok;

  lpf_ctrl #(.RVW(RVW)) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .pl_start(pl_start), .pl_end(pl_end),
    .suspend(suspend), .resume(resume), .resume_val(resume_val),
    .auto_on(auto_on), .auto_off(auto_off),
    .auto_q(auto_active), .saved_q(saved_auto)
  );

  lpf_fetch_gen #(.AW(AW)) i_fetch (
    .clk(clk), .rst_n(rst_n), .sh(sh),
    .trig_fire(trig_fire), .trig_addr(cand),
    .pl_start(pl_start), .pl_addr(pl_addr), .pl_size(pl_size),
    .pl_order(pl_order), .pl_end(pl_end),
    .freeze(freeze), .req_ready(req_ready),
    .req_valid(req_valid), .req_addr(req_addr),
    .pend(pend), .pl_active(pl_active)
  );

  assign pl_done = !pl_active;
  assign busy    = pl_active || pend;

  assert_done_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_start && pl_size != '0) |=> !pl_done);
  assert_busy_cover_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);
  assert_line_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_fire && cfg_line_sel == 2'd0) |=> (req_addr[3:0] == 4'd0));
endmodule

// File: tb/test_line_prefetch_top.sv
`timescale 1ns/1ps
module test_line_prefetch_top;
  localparam int AW = 24;
  localparam int NREG = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_line_sel = 0;
  logic cfg_dir = 0;
  logic [1:0] cfg_trig = 0;
  logic [NREG-1:0] cfg_reg_en = 0;
  logic [NREG*AW-1:0] cfg_reg_base = 0, cfg_reg_size = 0;
  logic auto_on = 0, auto_off = 0, suspend = 0, resume = 0;
  logic [7:0] resume_val = 0;
  logic pl_start = 0, pl_order = 0, pl_end = 0;
  logic [AW-1:0] pl_addr = 0, pl_size = 0, acc_addr = 0;
  logic acc_valid = 0, acc_hit = 0, freeze = 0, req_ready = 0;
  logic req_valid, auto_active, saved_auto, pl_done, busy;
  logic [AW-1:0] req_addr;

  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  line_prefetch_top #(.AW(AW), .NREG(NREG)) i_line_prefetch_top (
    .clk(clk), .rst_n(rst_n), .cfg_line_sel(cfg_line_sel), .cfg_dir(cfg_dir),
    .cfg_trig(cfg_trig), .cfg_reg_en(cfg_reg_en), .cfg_reg_base(cfg_reg_base),
    .cfg_reg_size(cfg_reg_size), .auto_on(auto_on), .auto_off(auto_off),
    .suspend(suspend), .resume(resume), .resume_val(resume_val),
    .pl_start(pl_start), .pl_addr(pl_addr), .pl_size(pl_size), .pl_order(pl_order),
    .pl_end(pl_end), .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_hit(acc_hit),
    .freeze(freeze), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .auto_active(auto_active), .saved_auto(saved_auto), .pl_done(pl_done), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_auto_on();
    auto_on = 1; tick(); auto_on = 0;
  endtask

  function automatic void exp_auto(input int a, input int hit, input int sel, input int dir,
                                   input int trig, input int en, input int b0, input int s0,
                                   input int b1, input int s1, output int v, output int na);
    int lb, line, rb, rs, n;
    bit tok;
    lb = 16 << ((sel > 2) ? 2 : sel);
    line = a - (a % lb);
    tok = (trig == 2) || (trig == 0 && hit == 0) || (trig == 1 && hit == 1);
    v = 0; na = 0;
    if (en[0] && a >= b0 && a < b0 + s0) begin rb = b0; rs = s0; end
    else if (en[1] && a >= b1 && a < b1 + s1) begin rb = b1; rs = s1; end
    else return;
    if (!tok) return;
    if (dir != 0 && line < lb) return;
    n = (dir != 0) ? line - lb : line + lb;
    if (n >= rb && n < rb + rs) begin v = 1; na = n; end
  endfunction

  task automatic set_regions(input int en, input int b0, input int s0, input int b1, input int s1);
    cfg_reg_en = en[1:0];
    cfg_reg_base = {AW'(b1), AW'(b0)};
    cfg_reg_size = {AW'(s1), AW'(s0)};
  endtask

  task automatic run_preload(input int start, input int size, input int order, input int sel,
                             input bit stall);
    int lb, lo, hi, n, exp_a, cnt, cyc;
    lb = 16 << sel;
    lo = start - (start % lb);
    hi = (start + size - 1) - ((start + size - 1) % lb);
    n = (size == 0) ? 0 : (hi - lo) / lb + 1;
    cfg_line_sel = sel[1:0];
    pl_addr = AW'(start); pl_size = AW'(size); pl_order = order[0];
    pl_start = 1; tick(); pl_start = 0;
    chk(pl_done == (n == 0), "R7 done flag after start", pl_done, n == 0);
    exp_a = order ? hi : lo;
    cnt = 0; cyc = 0;
    while (cnt < n && cyc < 400) begin
      chk(req_valid && req_addr == AW'(exp_a), "R7 preload line", req_addr, exp_a);
      chk(!auto_active, "R8 autoload off during preload", auto_active, 0);
      req_ready = stall ? (cyc % 3 != 0) : 1'b1;
      tick();
      if (req_ready) begin
        cnt++;
        exp_a = order ? exp_a - lb : exp_a + lb;
      end
      cyc++;
    end
    req_ready = 0;
    chk(pl_done == 1, "R7 done after walk", pl_done, 1);
    chk(req_valid == 0, "R6 no request after walk", req_valid, 0);
    chk(busy == 0, "R11 idle after walk", busy, 0);
  endtask

  initial begin
    #800000;
    nfail++;
    $display("FAIL watchdog R12 run did not finish actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int addrs [6] = '{'h1000, 'h13F0, 'h1234, 'h8010, 'h0500, 'h81FF};
    int v, na;
    tick(); tick();
    rst_n = 1;
    tick();
    // R12 reset state
    chk(auto_active == 0, "R12 auto_active", auto_active, 0);
    chk(saved_auto == 0, "R12 saved_auto", saved_auto, 0);
    chk(req_valid == 0, "R12 req_valid", req_valid, 0);
    chk(pl_done == 1, "R12 pl_done", pl_done, 1);
    chk(busy == 0, "R12 busy", busy, 0);

    // R1 R2 R3 R4 sweep
    set_regions(3, 'h1000, 'h400, 'h8000, 'h200);
    pulse_auto_on();
    for (int sel = 0; sel < 3; sel++)
      for (int dir = 0; dir < 2; dir++)
        for (int trig = 0; trig < 4; trig++)
          for (int hit = 0; hit < 2; hit++)
            for (int k = 0; k < 6; k++) begin
              cfg_line_sel = sel[1:0]; cfg_dir = dir[0]; cfg_trig = trig[1:0];
              exp_auto(addrs[k], hit, sel, dir, trig, 3, 'h1000, 'h400, 'h8000, 'h200, v, na);
              acc_valid = 1; acc_addr = AW'(addrs[k]); acc_hit = hit[0];
              tick();
              acc_valid = 0;
              chk(req_valid == v[0], "R2 R3 R4 request raised", req_valid, v);
              if (v != 0) begin
                chk(req_addr == AW'(na), "R1 R4 request line", req_addr, na);
                req_ready = 1; tick(); req_ready = 0;
                chk(req_valid == 0, "R6 drop after accept", req_valid, 0);
              end
            end

    // R3 disabled window and priority
    cfg_line_sel = 0; cfg_dir = 0; cfg_trig = 2;
    set_regions(1, 'h1000, 'h400, 'h8000, 'h200);
    acc_valid = 1; acc_addr = 'h8010; tick(); acc_valid = 0;
    chk(req_valid == 0, "R3 disabled window ignored", req_valid, 0);
    set_regions(3, 'h1000, 'h400, 'h1200, 'h400);
    acc_valid = 1; acc_addr = 'h13F0; tick(); acc_valid = 0;
    chk(req_valid == 0, "R3 lower window wins", req_valid, 0);
    set_regions(2, 'h1000, 'h400, 'h1200, 'h400);
    acc_valid = 1; acc_addr = 'h13F0; tick(); acc_valid = 0;
    chk(req_valid == 1 && req_addr == 'h1400, "R3 upper window alone", req_addr, 'h1400);
    req_ready = 1; tick(); req_ready = 0;

    // R5 replacement, R6 hold
    set_regions(3, 'h1000, 'h400, 'h8000, 'h200);
    acc_valid = 1; acc_addr = 'h1200; tick(); acc_valid = 0;
    tick();
    chk(req_valid && req_addr == 'h1210, "R6 held while not ready", req_addr, 'h1210);
    acc_valid = 1; acc_addr = 'h1300; tick();
    chk(req_addr == 'h1310, "R5 replaced while waiting", req_addr, 'h1310);
    acc_addr = 'h1100; req_ready = 1; tick(); acc_valid = 0; req_ready = 0;
    chk(req_valid && req_addr == 'h1110, "R5 replace wins over accept", req_addr, 'h1110);
    chk(busy == 1, "R11 busy while waiting", busy, 1);
    req_ready = 1; tick(); req_ready = 0;

    // R10 freeze drops autoload
    acc_valid = 1; acc_addr = 'h1200; tick(); acc_valid = 0;
    freeze = 1; tick();
    chk(req_valid == 0, "R10 frozen request hidden", req_valid, 1'b0);
    acc_valid = 1; acc_addr = 'h1300; tick(); acc_valid = 0; freeze = 0;
    #1;
    chk(req_valid == 0 && busy == 0, "R10 frozen fills dropped", req_valid, 0);

    // R7 R8 preload sweep
    run_preload('h2008, 'h50, 0, 0, 1);
    chk(saved_auto == 1, "R8 saved prior enable", saved_auto, 1);
    pl_end = 1; tick(); pl_end = 0;
    chk(auto_active == 1, "R8 end restores autoload", auto_active, 1);
    run_preload('h3010, 'h70, 1, 1, 1);
    pl_end = 1; tick(); pl_end = 0;
    for (int sel = 0; sel < 3; sel++)
      for (int ord = 0; ord < 2; ord++)
        for (int s = 0; s < 4; s++) begin
          int sz;
          sz = (s == 0) ? 0 : (s == 1) ? 1 : (s == 2) ? 'h40 : 'h41;
          run_preload('h4004, sz, ord, sel, 0);
          pl_end = 1; tick(); pl_end = 0;
        end

    // R10 freeze during preload
    cfg_line_sel = 0;
    pl_addr = 'h5000; pl_size = 'h40; pl_order = 0;
    pl_start = 1; tick(); pl_start = 0;
    freeze = 1; tick();
    chk(req_valid == 0, "R10 frozen preload hidden", req_valid, 0);
    tick(); freeze = 0; req_ready = 1; #1;
    chk(req_valid && req_addr == 'h5020, "R10 two lines discarded", req_addr, 'h5020);
    tick();
    chk(req_valid && req_addr == 'h5030, "R7 walk resumes", req_addr, 'h5030);
    tick(); req_ready = 0;
    chk(pl_done == 1, "R7 done after freeze walk", pl_done, 1);
    pl_end = 1; tick(); pl_end = 0;

    // R8 pl_end mid-walk
    pl_addr = 'h6000; pl_size = 'h100; pl_start = 1; tick(); pl_start = 0;
    chk(pl_done == 0 && busy == 1, "R7 R11 walking", pl_done, 0);
    pl_end = 1; tick(); pl_end = 0;
    chk(pl_done == 1 && req_valid == 0, "R8 end stops walk", req_valid, 0);
    chk(auto_active == 1, "R8 end restore", auto_active, 1);

    // R9 suspend / resume
    suspend = 1; tick(); suspend = 0;
    chk(auto_active == 0 && saved_auto == 1, "R9 suspend saves", saved_auto, 1);
    acc_valid = 1; acc_addr = 'h1200; tick(); acc_valid = 0;
    chk(req_valid == 0, "R9 suspended ignores access", req_valid, 0);
    resume = 1; resume_val = 8'h04; tick(); resume = 0;
    chk(auto_active == 1, "R9 resume nonzero", auto_active, 1);
    auto_off = 1; tick(); auto_off = 0;
    suspend = 1; tick(); suspend = 0;
    chk(saved_auto == 0, "R9 suspend from off", saved_auto, 0);
    resume = 1; resume_val = 8'h00; tick(); resume = 0;
    chk(auto_active == 0, "R9 resume zero", auto_active, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule